// File: doc/BRIEF.md
# Reset Pin Spike Filter

This block turns a noisy, active-low external reset pin into a clean synchronous reset for the rest of the chip. The pin is first brought into the clock domain. A low level then has to persist for a set number of clock cycles before it counts as a reset. Brief high glitches that arrive while the pin is low do not cancel a reset that is already in progress, and they do not cancel one that is still being timed. A high level ends the low episode only once it has lasted for a separate, shorter number of cycles.

A one-cycle software reset request has the same effect as an accepted pin reset. When the reset drops, a recovery counter runs. The `ready` flag goes high only after that counter completes. The power-on reset comes from elsewhere on the chip and puts the block into its reset state.

All thresholds are clock-cycle parameters. `LOW_CYC` must lie between the reject width (`REJECT_CYC`) and the accept width (`ACCEPT_CYC`) that the system needs. The pin itself passes through `SYNC_STAGES` flops, and the requirements below count that delay.

Top module: `rstf_top`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1 and `ready` is 0. If the pin stays high, `rst_out` is 0 after the first clock edge following the release of `por_n`, and `ready` rises on edge 1+`REC_CYC`.
- R2: A low pulse on `pin_n` lasting at most `LOW_CYC`−`SPIKE_CYC` sampled cycles never raises `rst_out`. Throughout, `ready` stays 1.
- R3: A low level held on `pin_n` raises `rst_out` on clock edge `SYNC_STAGES`+`LOW_CYC`+1, counted from the first edge that samples the pin low. A low pulse of `LOW_CYC`−`SPIKE_CYC`+1 cycles is just long enough to produce a reset.
- R4: Once `rst_out` is high, a high excursion on `pin_n` shorter than `SPIKE_CYC` cycles leaves `rst_out` high without a gap.
- R5: When `pin_n` returns high and stays high, `rst_out` falls on edge `SYNC_STAGES`+`SPIKE_CYC`+1, counted from the first edge that samples it high.
- R6: `ready` is 0 whenever `rst_out` is 1. It rises exactly `REC_CYC` edges after the edge on which `rst_out` falls, and it stays high until the next reset.
- R7: A one-cycle pulse on `sw_rst` sets `rst_out` to 1 on the next edge, for one cycle. Recovery then follows as in R6.
- R8: A high excursion shorter than `SPIKE_CYC` cycles inside a low pulse that is not yet accepted leaves the width count running across it. A high lasting `SPIKE_CYC` cycles restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset from the chip, active low, asynchronous |
| pin_n | input | 1 | Raw external reset pin, active low, asynchronous |
| sw_rst | input | 1 | Software reset request, one-cycle pulse |
| rst_out | output | 1 | Clean internal reset, active high |
| ready | output | 1 | High once recovery after the last reset has completed |

## Verification
The pin is driven with four kinds of stimulus:

- **Isolated low pulses.** Widths well below the threshold, and one cycle either side of the acceptance boundary, show whether the low-width count and the spike window are added together correctly.
- **A held low level.** Short high blips are dropped into it to tell spike rejection apart from a true release.
- **Split pulses inside an unaccepted low.** One has a sub-window high and the other a full-window high. They tell "count keeps running" apart from "count restarts".
- **Software pulses.** These show that the request path and the pin path share the same recovery timing.

A behavioural model in the bench predicts both outputs on every cycle of all of these patterns.

// File: rtl/rstf_pkg.sv
`timescale 1ns/1ps
package rstf_pkg;

   // Phase of the low-pulse qualifier, shared between qualifier and top
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,   // no low episode in progress
      PH_TIMING = 2'd1,   // low episode being measured
      PH_HELD   = 2'd2    // low episode accepted as a reset
   } qual_phase_t;

endpackage

// File: rtl/rstf_sync.sv
`timescale 1ns/1ps
module rstf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) chain_q <= '1;
            else        chain_q <= {chain_q[0], din};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rstf_qualify.sv
`timescale 1ns/1ps
module rstf_qualify
   import rstf_pkg::*;
#(
   parameter int LOW_CYC   = 1500,
   parameter int SPIKE_CYC = 4
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        pin_s,      // synchronised pin, active low
   output qual_phase_t phase
);

   localparam int LW = $clog2(LOW_CYC + 1);
   localparam logic [LW-1:0] LOW_MAX = LW'(LOW_CYC);

   logic [LW-1:0] low_q;
   logic          in_episode;
   logic          at_max;
   logic          release_c;

   assign in_episode = (low_q != '0);
   assign at_max     = (low_q == LOW_MAX);

   // Spike window: picks how a high level ends a low episode
   generate
      if (SPIKE_CYC == 1) begin : g_no_window
         assign release_c = pin_s && in_episode;
      end else begin : g_window
         localparam int HW = $clog2(SPIKE_CYC);
         localparam logic [HW-1:0] HIGH_LAST = HW'(SPIKE_CYC - 1);
         logic [HW-1:0] high_q;

         assign release_c = pin_s && in_episode && (high_q == HIGH_LAST);

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                       high_q <= '0;
            else if (!pin_s || !in_episode)   high_q <= '0;
            else if (release_c)               high_q <= '0;
            else                              high_q <= high_q + 1'b1;
         end
      end
   endgenerate

   // Low-width counter: runs through short highs, saturates once accepted
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         low_q <= '0;
      end else if (!pin_s) begin
         if (!at_max) low_q <= low_q + 1'b1;
      end else if (release_c) begin
         low_q <= '0;
      end else if (in_episode && !at_max) begin
         low_q <= low_q + 1'b1;
      end
   end

   always_comb begin
      if (at_max)          phase = PH_HELD;
      else if (in_episode) phase = PH_TIMING;
      else                 phase = PH_IDLE;
   end

endmodule

// File: rtl/rstf_recover.sv
`timescale 1ns/1ps
module rstf_recover #(
   parameter int REC_CYC = 100
) (
   input  logic clk,
   input  logic por_n,
   input  logic hw_req,
   input  logic sw_req,
   output logic rst_out,
   output logic ready
);

   localparam int RW = $clog2(REC_CYC + 1);
   localparam logic [RW-1:0] REC_MAX = RW'(REC_CYC);

   logic          rst_q;
   logic [RW-1:0] rec_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) rst_q <= 1'b1;
      else        rst_q <= hw_req | sw_req;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                rec_q <= '0;
      else if (rst_q)            rec_q <= '0;
      else if (rec_q != REC_MAX) rec_q <= rec_q + 1'b1;
   end

   assign rst_out = rst_q;
   assign ready   = (rec_q == REC_MAX) && !rst_q;

endmodule

// File: rtl/rstf_top.sv
`timescale 1ns/1ps
module rstf_top
   import rstf_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int REJECT_CYC  = 1000,
   parameter int ACCEPT_CYC  = 2000,
   parameter int LOW_CYC     = 1500,
   parameter int SPIKE_CYC   = 4,
   parameter int REC_CYC     = 100
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   input  logic sw_rst,
   output logic rst_out,
   output logic ready
);

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rstf_top: SYNC_STAGES must be at least 2");
   end
   if (!(LOW_CYC > REJECT_CYC && LOW_CYC <= ACCEPT_CYC)) begin : g_bad_low
      $error("rstf_top: LOW_CYC must lie above REJECT_CYC and not above ACCEPT_CYC");
   end
   if (SPIKE_CYC < 1 || SPIKE_CYC >= LOW_CYC) begin : g_bad_spike
      $error("rstf_top: SPIKE_CYC must be in 1..LOW_CYC-1");
   end
   if (REC_CYC < 1) begin : g_bad_rec
      $error("rstf_top: REC_CYC must be at least 1");
   end

   logic        pin_s;
   qual_phase_t phase;
   logic        hw_req;

   rstf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .din   (pin_n),
      .dout  (pin_s)
   );

   rstf_qualify #(.LOW_CYC(LOW_CYC), .SPIKE_CYC(SPIKE_CYC)) u_qual (
      .clk   (clk),
      .por_n (por_n),
      .pin_s (pin_s),
      .phase (phase)
   );

   assign hw_req = (phase == PH_HELD);

   rstf_recover #(.REC_CYC(REC_CYC)) u_rec (
      .clk     (clk),
      .por_n   (por_n),
      .hw_req  (hw_req),
      .sw_req  (sw_rst),
      .rst_out (rst_out),
      .ready   (ready)
   );

endmodule

// File: rtl/rstf_checker.sv
`timescale 1ns/1ps
module rstf_checker #(
   parameter int REC_CYC = 100
) (
   input logic clk,
   input logic por_n,
   input logic sw_rst,
   input logic rst_out,
   input logic ready
);

   localparam int CW = $clog2(REC_CYC + 1);
   localparam logic [CW-1:0] CMAX = CW'(REC_CYC);

   // Cycles since rst_out was last seen high, saturating
   logic [CW-1:0] quiet_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)               quiet_q <= '0;
      else if (rst_out)         quiet_q <= '0;
      else if (quiet_q != CMAX) quiet_q <= quiet_q + 1'b1;
   end

   // R6: ready never overlaps the reset
   a_r6_ready_low_in_reset: assert property (@(posedge clk) disable iff (!por_n)
      rst_out |-> !ready);

   // R6: ready is kept until a reset arrives
   a_r6_ready_holds: assert property (@(posedge clk) disable iff (!por_n)
      ready |=> (ready || rst_out));

   // R6: ready rises only when the full recovery window has elapsed
   a_r6_recovery_window: assert property (@(posedge clk) disable iff (!por_n)
      $rose(ready) |-> (quiet_q == CMAX));

   // R7: a software request always yields a reset on the next cycle
   a_r7_sw_takes_effect: assert property (@(posedge clk) disable iff (!por_n)
      sw_rst |=> rst_out);

endmodule

bind rstf_top rstf_checker #(.REC_CYC(REC_CYC)) u_chk (
   .clk     (clk),
   .por_n   (por_n),
   .sw_rst  (sw_rst),
   .rst_out (rst_out),
   .ready   (ready)
);

// File: tb/rstf_top_test.sv
`timescale 1ns/1ps
module rstf_top_test;

   localparam int SYNC  = 2;
   localparam int LOW   = 20;
   localparam int SPIKE = 4;
   localparam int REC   = 8;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic pin_n = 1'b1;
   logic sw_rst = 1'b0;
   logic rst_out;
   logic ready;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rstf_top #(
      .SYNC_STAGES(SYNC), .REJECT_CYC(10), .ACCEPT_CYC(30),
      .LOW_CYC(LOW), .SPIKE_CYC(SPIKE), .REC_CYC(REC)
   ) uut (
      .clk(clk), .por_n(por_n), .pin_n(pin_n), .sw_rst(sw_rst),
      .rst_out(rst_out), .ready(ready)
   );

   // Behavioural reference model
   int  m_pipe[$];
   int  m_low, m_high, m_rec, m_s;
   bit  m_rst, m_held;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_pipe = {};
         for (int i = 0; i < SYNC; i++) m_pipe.push_back(1);
         m_low = 0; m_high = 0; m_rec = 0; m_rst = 1'b1;
      end else begin
         m_s    = m_pipe.pop_front();
         m_pipe.push_back(int'(pin_n));
         m_held = (m_low == LOW);
         if (m_rst) m_rec = 0;
         else if (m_rec < REC) m_rec++;
         m_rst = m_held || sw_rst;
         if (m_s == 0) begin
            m_high = 0;
            if (m_low < LOW) m_low++;
         end else if (m_low > 0) begin
            if (m_high == SPIKE - 1) begin
               m_low = 0; m_high = 0;
            end else begin
               m_high++;
               if (m_low < LOW) m_low++;
            end
         end
      end
   end

   task automatic chk(string req, logic act, logic exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // Model comparison on every cycle, away from the active edge
   always @(negedge clk) begin
      if (por_n && !done) begin
         chk("R3", rst_out, m_rst, "rst_out vs model");
         chk("R6", ready, (m_rec == REC) && !m_rst, "ready vs model");
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // Watch a window: returns whether rst_out was seen high, and whether ready ever dropped
   task automatic watch(int n, output bit saw_rst, output bit saw_drop);
      saw_rst = 0; saw_drop = 0;
      repeat (n) begin
         @(negedge clk);
         if (rst_out) saw_rst = 1;
         if (!ready) saw_drop = 1;
      end
   endtask

   task automatic pulse(int w);
      pin_n = 1'b0;
      cyc(w);
      pin_n = 1'b1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      bit sr, sd;
      // R1: reset state and first recovery
      cyc(3);
      chk("R1", rst_out, 1'b1, "rst_out during por");
      chk("R1", ready, 1'b0, "ready during por");
      por_n = 1'b1;
      cyc(1);
      chk("R1", rst_out, 1'b0, "rst_out after por edge 1");
      cyc(REC - 1);
      chk("R1", ready, 1'b0, "ready before recovery");
      cyc(1);
      chk("R1", ready, 1'b1, "ready after recovery");
      cyc(5);

      // R3: latency of a held low
      pin_n = 1'b0;
      cyc(SYNC + LOW);
      chk("R3", rst_out, 1'b0, "rst_out one edge early");
      cyc(1);
      chk("R3", rst_out, 1'b1, "rst_out at acceptance");
      chk("R6", ready, 1'b0, "ready in reset");
      cyc(5);

      // R4: short high spike while held
      pin_n = 1'b1;
      begin
         bit low_seen = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 2) pin_n = 1'b0;
            if (!rst_out) low_seen = 1;
         end
         chk("R4", low_seen, 1'b0, "rst_out gap during spike");
      end

      // R5 / R6: release and recovery
      pin_n = 1'b1;
      cyc(SYNC + SPIKE);
      chk("R5", rst_out, 1'b1, "rst_out before release");
      cyc(1);
      chk("R5", rst_out, 1'b0, "rst_out after release");
      cyc(REC - 1);
      chk("R6", ready, 1'b0, "ready one edge early");
      cyc(1);
      chk("R6", ready, 1'b1, "ready after recovery window");
      cyc(5);

      // R2: short pulses rejected
      pulse(10);
      watch(40, sr, sd);
      chk("R2", sr, 1'b0, "reset from 10-cycle pulse");
      chk("R2", sd, 1'b0, "ready drop from 10-cycle pulse");
      pulse(LOW - SPIKE);
      watch(40, sr, sd);
      chk("R2", sr, 1'b0, "reset from boundary-reject pulse");

      // R3: shortest accepted pulse
      pulse(LOW - SPIKE + 1);
      watch(40, sr, sd);
      chk("R3", sr, 1'b1, "reset from boundary-accept pulse");
      chk("R6", ready, 1'b1, "ready back after short reset");

      // R8: sub-window high keeps counting
      pulse(8); cyc(2); pulse(12);
      watch(40, sr, sd);
      chk("R8", sr, 1'b1, "split pulse with short high");
      // R8: full-window high restarts the count
      pulse(8); cyc(SPIKE); pulse(10);
      watch(40, sr, sd);
      chk("R8", sr, 1'b0, "split pulse with full high");

      // R7: software request
      sw_rst = 1'b1;
      cyc(1);
      sw_rst = 1'b0;
      chk("R7", rst_out, 1'b1, "rst_out after sw pulse");
      chk("R7", ready, 1'b0, "ready after sw pulse");
      cyc(1);
      chk("R7", rst_out, 1'b0, "rst_out one cycle long");
      cyc(REC - 1);
      chk("R7", ready, 1'b0, "ready before sw recovery");
      cyc(1);
      chk("R7", ready, 1'b1, "ready after sw recovery");

      cyc(4);
      finish_run();
   end

endmodule